// File: doc/BRIEF.md
# Sequenced Multiply-Add Array Kernel

This block processes a short array held in an external single-port memory. For every element x it computes y = a*x + b + c and writes y to the same index of a second external memory. The scalars a, b and c are 8-bit two's-complement inputs. The array words and the results are 32 bits wide. Neither memory is inside the block. The block drives only the address, chip-enable and write-enable lines, and it consumes the read data with a latency of one cycle.

A four-state control machine steps through the elements in order. Each element takes three cycles: one to read, one to form a*x+b into a register, and one to add c and write. A one-cycle `start` pulse in the idle state begins a run and captures the scalars. A one-cycle `done` pulse closes the run.

Top module: `mac_seq_kernel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `in_ce`, `out_ce`, `out_we` and `done` are all low and the block is idle. A reset in the middle of a run abandons it, and no further write occurs.
- R2: When `start` is high in the idle state, the next cycle has `in_ce` high with `in_addr` equal to 0.
- R3: The block uses the `in_rdata` value from the cycle after the one in which it asserted `in_ce`. The memory therefore has one cycle of read latency.
- R4: Elements are handled in index order 0, 1, 2. The write of an element occurs exactly two cycles after its read. Each element takes three cycles.
- R5: For each element, `out_ce` and `out_we` are high together for exactly one cycle, with `out_addr` equal to the element index. Each run makes exactly COUNT (default 3) writes, at addresses 0 to COUNT-1.
- R6: `out_data` equals a*x+b+c. Here a, b and c are sign-extended from 8 to 32 bits, x is the 32-bit word that was read, and the result wraps modulo 2^32.
- R7: Changes on `a`, `b` and `c` after the start cycle have no effect on the results of the run.
- R8: A `start` pulse while a run is in progress is ignored. The run neither restarts nor makes extra writes.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the last write, and the block is idle in it, ready for a new `start`.
- R10: `in_ce` and `out_ce` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled in idle only) |
| a | input | 8 | Signed multiplier scalar |
| b | input | 8 | Signed first addend |
| c | input | 8 | Signed second addend |
| done | output | 1 | One-cycle end-of-run pulse |
| in_addr | output | ADDR_W | Input memory address |
| in_ce | output | 1 | Input memory chip-enable |
| in_rdata | input | DATA_W | Input memory read data, valid one cycle after `in_ce` |
| out_addr | output | ADDR_W | Output memory address |
| out_ce | output | 1 | Output memory chip-enable |
| out_we | output | 1 | Output memory write-enable |
| out_data | output | DATA_W | Result word to write |

## Verification
The assertions check the control timing on every cycle:
- the read at address 0 that follows an accepted start;
- the two-cycle spacing from a read to its write at the same address;
- single-cycle write strobes;
- the one-cycle `done` that comes right after the final write;
- the mutual exclusion of the two chip-enables;
- the holding of the captured scalars while a run is in progress.

The arithmetic can be judged only by the bench scenarios, which compare the written words with an independent reference over signed extremes and wrapping. The same holds for the immunity to scalar changes and to repeated starts during a run, and for the abandonment of a run by reset.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MAC   = 2'd2,
    ST_WRITE = 2'd3
  } kstate_t;

endpackage

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import mac_seq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int COUNT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              accept,
  output logic              mac_en,
  output logic              in_ce,
  output logic [ADDR_W-1:0] in_addr,
  output logic              out_ce,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(COUNT - 1);

  kstate_t           state_q;
  logic [ADDR_W-1:0] idx_q;
  logic              done_q;

  always_comb begin
    accept   = (state_q == ST_IDLE) && start;
    mac_en   = (state_q == ST_MAC);
    in_ce    = (state_q == ST_READ);
    out_ce   = (state_q == ST_WRITE);
    out_we   = (state_q == ST_WRITE);
    in_addr  = idx_q;
    out_addr = idx_q;
    done     = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            idx_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ:  state_q <= ST_MAC;
        ST_MAC:   state_q <= ST_WRITE;
        ST_WRITE: begin
          if (idx_q == LAST_IDX) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_read_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (in_ce && in_addr == '0));

  // R4
  read_to_write_chk: assert property (@(posedge clk) disable iff (rst)
    in_ce |-> ##2 (out_ce && out_addr == $past(in_addr, 2)));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_ce |=> !out_ce);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_ce) && $past(out_addr) == LAST_IDX));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  ce_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ce && out_ce));

endmodule

// File: rtl/mac_seq_dp.sv
module mac_seq_dp #(
  parameter int DATA_W = 32,
  parameter int SCAL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mac_en,
  input  logic [SCAL_W-1:0] a,
  input  logic [SCAL_W-1:0] b,
  input  logic [SCAL_W-1:0] c,
  input  logic [DATA_W-1:0] in_rdata,
  output logic [DATA_W-1:0] out_data
);

  localparam int EXT_W = DATA_W - SCAL_W;

  logic [SCAL_W-1:0] a_q, b_q, c_q;
  logic [DATA_W-1:0] a_ext, b_ext, c_ext;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] part_q;

  always_comb begin
    a_ext    = {{EXT_W{a_q[SCAL_W-1]}}, a_q};
    b_ext    = {{EXT_W{b_q[SCAL_W-1]}}, b_q};
    c_ext    = {{EXT_W{c_q[SCAL_W-1]}}, c_q};
    prod     = a_ext * in_rdata;
    out_data = part_q + c_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      part_q <= '0;
    end else begin
      if (load) begin
        a_q <= a;
        b_q <= b;
        c_q <= c;
      end
      if (mac_en) part_q <= prod + b_ext;
    end
  end

  // R7
  hold_scalar_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

endmodule

// File: rtl/mac_seq_kernel.sv
module mac_seq_kernel #(
  parameter int DATA_W = 32,
  parameter int SCAL_W = 8,
  parameter int ADDR_W = 2,
  parameter int COUNT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SCAL_W-1:0] a,
  input  logic [SCAL_W-1:0] b,
  input  logic [SCAL_W-1:0] c,
  output logic              done,
  output logic [ADDR_W-1:0] in_addr,
  output logic              in_ce,
  input  logic [DATA_W-1:0] in_rdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ce,
  output logic              out_we,
  output logic [DATA_W-1:0] out_data
);

  logic accept;
  logic mac_en;

  mac_seq_ctrl #(
    .ADDR_W(ADDR_W),
    .COUNT (COUNT)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .accept  (accept),
    .mac_en  (mac_en),
    .in_ce   (in_ce),
    .in_addr (in_addr),
    .out_ce  (out_ce),
    .out_we  (out_we),
    .out_addr(out_addr),
    .done    (done)
  );

  mac_seq_dp #(
    .DATA_W(DATA_W),
    .SCAL_W(SCAL_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .mac_en  (mac_en),
    .a       (a),
    .b       (b),
    .c       (c),
    .in_rdata(in_rdata),
    .out_data(out_data)
  );

endmodule

// File: tb/mac_seq_kernel_bench.sv
module mac_seq_kernel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  a = '0, b = '0, c = '0;
  logic        done;
  logic [1:0]  in_addr, out_addr;
  logic        in_ce, out_ce, out_we;
  logic [31:0] in_rdata;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] imem [4];
  logic [31:0] omem [4];
  int          wr_cnt;
  int          rd_cnt;
  int          wr_addr [8];
  int          wr_cyc  [8];
  int          rd_addr [8];
  int          rd_cyc  [8];
  int          cyc = 0;
  bit          ce_clash = 0;
  bit          strobe_mismatch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_seq_kernel u_mac_seq_kernel (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .c(c),
    .done(done), .in_addr(in_addr), .in_ce(in_ce), .in_rdata(in_rdata),
    .out_addr(out_addr), .out_ce(out_ce), .out_we(out_we), .out_data(out_data)
  );

  // behavioural memories and port monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_ce) begin
      in_rdata <= imem[in_addr];
      if (rd_cnt < 8) begin
        rd_addr[rd_cnt] = int'(in_addr);
        rd_cyc[rd_cnt]  = cyc;
      end
      rd_cnt = rd_cnt + 1;
    end else begin
      in_rdata <= 32'hDEAD_BEEF;
    end
    if (in_ce && out_ce) ce_clash = 1;
    if (out_ce != out_we) strobe_mismatch = 1;
    if (out_ce && out_we) begin
      omem[out_addr] <= out_data;
      if (wr_cnt < 8) begin
        wr_addr[wr_cnt] = int'(out_addr);
        wr_cyc[wr_cnt]  = cyc;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_y(input logic signed [7:0] sa,
      input logic signed [7:0] sb, input logic signed [7:0] sc, input logic [31:0] x);
    logic signed [31:0] ea, eb, ec;
    ea = sa; eb = sb; ec = sc;
    return ea * $signed(x) + eb + ec;
  endfunction

  task automatic clear_log();
    wr_cnt = 0; rd_cnt = 0;
    for (int i = 0; i < 4; i++) omem[i] = 32'h0BAD_0BAD;
  endtask

  // runs one job; optionally disturbs scalars and start mid-run (R7, R8)
  task automatic run_job(input string name, input logic [7:0] ja, input logic [7:0] jb,
                         input logic [7:0] jc, input logic [31:0] x0, input logic [31:0] x1,
                         input logic [31:0] x2, input bit disturb);
    int waited;
    bit seen;
    imem[0] = x0; imem[1] = x1; imem[2] = x2; imem[3] = 32'h5555_5555;
    clear_log();
    @(negedge clk);
    a = ja; b = jb; c = jc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2
    chk(in_ce && in_addr == 2'd0, "R2", {name, " first read"}, {30'd0, in_addr}, 32'd0);
    waited = 0; seen = 0;
    while (waited < 20 && !seen) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 2) begin
        a = ~ja; b = jb + 8'd33; c = jc ^ 8'h5A; start = 1'b1;
      end
      if (disturb && waited == 5) start = 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    // R9
    chk(seen && waited == 3*N, "R9", {name, " done timing"}, waited, 3*N);
    chk(!in_ce && !out_ce, "R9", {name, " idle at done"}, {in_ce, out_ce}, 0);
    @(negedge clk);
    chk(!done, "R9", {name, " done width"}, done, 0);
    // R5 / R8
    chk(wr_cnt == N, "R5", {name, " write count"}, wr_cnt, N);
    chk(rd_cnt == N, "R8", {name, " read count"}, rd_cnt, N);
    for (int i = 0; i < N && i < wr_cnt && i < rd_cnt; i++) begin
      chk(wr_addr[i] == i, "R5", {name, " write addr"}, wr_addr[i], i);
      chk(rd_addr[i] == i, "R4", {name, " read order"}, rd_addr[i], i);
      chk(wr_cyc[i] - rd_cyc[i] == 2, "R4", {name, " read-to-write gap"},
          wr_cyc[i] - rd_cyc[i], 2);
    end
    // R6 / R3 / R7
    for (int i = 0; i < N; i++)
      chk(omem[i] == ref_y(ja, jb, jc, imem[i]), disturb ? "R7" : "R6",
          {name, " result"}, omem[i], ref_y(ja, jb, jc, imem[i]));
    chk(omem[3] == 32'h0BAD_0BAD, "R5", {name, " no write past end"}, omem[3], 32'h0BAD_0BAD);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!in_ce && !out_ce && !out_we && !done, "R1", "outputs during reset",
        {in_ce, out_ce, out_we, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!in_ce && !out_ce && !out_we && !done, "R1", "outputs after reset",
        {in_ce, out_ce, out_we, done}, 0);
  endtask

  task automatic t_reset_mid_run();
    clear_log();
    imem[0] = 32'd1; imem[1] = 32'd2; imem[2] = 32'd3;
    @(negedge clk);
    a = 8'd2; b = 8'd0; c = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!in_ce && !out_ce && !done, "R1", "idle after mid-run reset",
        {in_ce, out_ce, done}, 0);
    repeat (12) @(negedge clk);
    chk(wr_cnt == 0, "R1", "no write after abort", wr_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) imem[i] = '0;
    clear_log();
    t_reset();
    run_job("small", 8'd3, 8'd5, 8'd7, 32'd10, 32'd0, 32'd1, 0);
    run_job("signed", 8'hFD, 8'h80, 8'h7F, 32'hFFFF_FFF6, 32'd100, 32'h8000_0000, 0);
    run_job("extreme", 8'h80, 8'h7F, 8'h80, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_job("wrap", 8'h7F, 8'h7F, 8'h7F, 32'h4000_0000, 32'h0200_0001, 32'h7FFF_FFFF, 0);
    run_job("disturbed", 8'd9, 8'hF0, 8'd1, 32'd12345, 32'hFFFF_0000, 32'd77, 1);
    t_reset_mid_run();
    run_job("after abort", 8'h01, 8'h00, 8'h00, 32'hCAFE_F00D, 32'd1, 32'd2, 0);
    // R10
    chk(!ce_clash, "R10", "chip-enable overlap", ce_clash, 0);
    chk(!strobe_mismatch, "R5", "ce/we paired", strobe_mismatch, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule